// File: doc/BRIEF.md
# Translation Domain and Permission Checker

This block decides whether one memory access may proceed once its first-level translation entry is known. It takes the entry's 4-bit domain number, the 32-bit domain control word held by the translation unit, the entry's 2-bit permission code and its no-execute bit, and the kind of access (read, write or instruction fetch, with a privilege flag). It reports one of three outcomes: the access passes, it takes a domain fault, or it takes a permission fault.

The decision has two stages. The control word gives each domain a 2-bit mode. That mode either blocks every access, sends the access to the permission check, or lets it through with no permission check at all. Only accesses that reach the permission check see the no-execute bit. The result is registered and appears one cycle after the request, with a one-cycle valid pulse.

Top module: `dac_domain_check`

## Requirements
- R1: The domain number n selects bits [2n+1:2n] of the control word as the mode of that access, for n from 0 to 15. The fields of other domains have no effect.
- R2: Mode 00 (blocked) gives a domain fault for every access, whatever the permission code, kind or privilege.
- R3: Mode 10 (reserved) behaves exactly like mode 00 and gives a domain fault.
- R4: Mode 01 (checked) applies the permission code. 00 allows privileged read and write and rejects user access. 01 allows read and write at any privilege. 10 allows reads at any privilege and rejects writes. 11 allows privileged reads only. A rejected access gives a permission fault.
- R5: In mode 01, an instruction fetch (kind 10) from an entry with the no-execute bit set gives a permission fault. The bit has no effect on reads and writes.
- R6: Mode 11 (trusted) always passes, whatever the permission code, no-execute bit, kind or privilege.
- R7: Whenever the output valid is high, exactly one of pass, domain fault and permission fault is high. A domain fault takes priority over a permission fault.
- R8: A request with input valid high produces its result and an output valid pulse on the next clock edge. Without a request, output valid is low and the three result outputs keep their last values, even when the other inputs change.
- R9: During and straight after reset, output valid and all three result outputs are low.
- R10: Access kind 00 is a read, 01 a write and 10 a fetch. Kind 11 is checked as a plain read and is never treated as a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| dom_idx | input | 4 | Domain number from the translation entry |
| dom_ctrl | input | 32 | Domain control word, 2 bits per domain |
| perm_code | input | 2 | Permission code of the entry |
| no_exec | input | 1 | No-execute bit of the entry |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| acc_priv | input | 1 | 1 for a privileged access |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_pass | output | 1 | Access allowed |
| out_dom_fault | output | 1 | Domain fault |
| out_perm_fault | output | 1 | Permission fault |

## Verification
The assertions assume that every request input is stable and known in the cycle where in_valid is high. Between requests they only rely on in_valid itself, because the other inputs are ignored there. The bench changes inputs only on falling edges. It holds each request for exactly one cycle, or for back-to-back cycles. Between requests it scrambles the control word, so that the hold assertions and checks face inputs that change without a request.

// File: rtl/dac_pkg.sv
package dac_pkg;

  typedef enum logic [1:0] {
    DM_BLOCKED = 2'b00,
    DM_CHECKED = 2'b01,
    DM_RSVD    = 2'b10,
    DM_TRUSTED = 2'b11
  } dom_mode_e;

  typedef enum logic [1:0] {
    AK_READ  = 2'b00,
    AK_WRITE = 2'b01,
    AK_FETCH = 2'b10,
    AK_ALT   = 2'b11
  } acc_kind_e;

  // Permission table of the simplified model: returns 1 when allowed.
  function automatic logic perm_allows(input logic [1:0] code,
                                       input logic       is_write,
                                       input logic       is_priv);
    logic ok;
    case (code)
      2'b00:   ok = is_priv;
      2'b01:   ok = 1'b1;
      2'b10:   ok = !is_write;
      default: ok = is_priv && !is_write;
    endcase
    return ok;
  endfunction

  // Mode decoding: does this mode raise a domain fault?
  function automatic logic mode_blocks(input dom_mode_e m);
    return (m == DM_BLOCKED) || (m == DM_RSVD);
  endfunction

endpackage

// File: rtl/dac_field_sel.sv
module dac_field_sel
  import dac_pkg::*;
#(
  parameter int NUM_DOM = 16,
  localparam int DOM_W  = $clog2(NUM_DOM),
  localparam int CTRL_W = 2 * NUM_DOM
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DOM_W-1:0]  idx,
  output dom_mode_e         mode
);

  logic [1:0] fields [NUM_DOM];

  // Split the control word into one 2-bit field per domain.
  for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
    assign fields[g] = ctrl[2*g +: 2];
  end

  assign mode = dom_mode_e'(fields[idx]);

endmodule

// File: rtl/dac_perm_eval.sv
module dac_perm_eval
  import dac_pkg::*;
(
  input  logic [1:0] code,
  input  logic       no_exec,
  input  acc_kind_e  kind,
  input  logic       is_priv,
  output logic       perm_ok
);

  logic is_write;
  logic is_fetch;
  logic fetch_blocked;

  // Kind 11 is neither a write nor a fetch, so it is checked as a read.
  assign is_write      = (kind == AK_WRITE);
  assign is_fetch      = (kind == AK_FETCH);
  assign fetch_blocked = is_fetch && no_exec;
  assign perm_ok       = perm_allows(code, is_write, is_priv) && !fetch_blocked;

endmodule

// File: rtl/dac_domain_check.sv
module dac_domain_check
  import dac_pkg::*;
#(
  parameter int NUM_DOM = 16,
  localparam int DOM_W  = $clog2(NUM_DOM),
  localparam int CTRL_W = 2 * NUM_DOM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DOM_W-1:0]  dom_idx,
  input  logic [CTRL_W-1:0] dom_ctrl,
  input  logic [1:0]        perm_code,
  input  logic              no_exec,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  output logic              out_valid,
  output logic              out_pass,
  output logic              out_dom_fault,
  output logic              out_perm_fault
);

  dom_mode_e mode_sel;
  logic      perm_ok;
  logic      dom_fault_c;
  logic      perm_fault_c;
  logic      pass_c;
  logic      is_fetch_xn;

  dac_field_sel #(.NUM_DOM(NUM_DOM)) u_field_sel (
    .ctrl (dom_ctrl),
    .idx  (dom_idx),
    .mode (mode_sel)
  );

  dac_perm_eval u_perm_eval (
    .code    (perm_code),
    .no_exec (no_exec),
    .kind    (acc_kind_e'(acc_kind)),
    .is_priv (acc_priv),
    .perm_ok (perm_ok)
  );

  // First stage: domain; second stage: permission, only for checked domains.
  assign dom_fault_c  = mode_blocks(mode_sel);
  assign perm_fault_c = (mode_sel == DM_CHECKED) && !perm_ok;
  assign pass_c       = !dom_fault_c && !perm_fault_c;
  assign is_fetch_xn  = (acc_kind == 2'b10) && no_exec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_pass       <= 1'b0;
      out_dom_fault  <= 1'b0;
      out_perm_fault <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pass       <= pass_c;
        out_dom_fault  <= dom_fault_c;
        out_perm_fault <= perm_fault_c;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_pass, out_dom_fault, out_perm_fault}) == 1); // R7

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({out_pass, out_dom_fault, out_perm_fault})); // R8

  AST_BLOCKED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode_sel == DM_BLOCKED)) |=> out_dom_fault); // R2

  AST_RSVD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode_sel == DM_RSVD)) |=> out_dom_fault); // R3

  AST_TRUSTED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode_sel == DM_TRUSTED)) |=> out_pass); // R6

  AST_XN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode_sel == DM_CHECKED) && is_fetch_xn) |=> out_perm_fault); // R5

  AST_CHECKED_NO_DFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode_sel == DM_CHECKED)) |=> !out_dom_fault); // R4

endmodule

// File: tb/dac_domain_check_bench.sv
module dac_domain_check_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  dom_idx = '0;
  logic [31:0] dom_ctrl = '0;
  logic [1:0]  perm_code = '0;
  logic        no_exec = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic        acc_priv = 1'b0;
  logic        out_valid, out_pass, out_dom_fault, out_perm_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_domain_check u_dac_domain_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dom_idx(dom_idx),
    .dom_ctrl(dom_ctrl), .perm_code(perm_code), .no_exec(no_exec),
    .acc_kind(acc_kind), .acc_priv(acc_priv), .out_valid(out_valid),
    .out_pass(out_pass), .out_dom_fault(out_dom_fault),
    .out_perm_fault(out_perm_fault)
  );

  // {dom, mode, perm, xn, kind, priv, expected {pass, dfault, pfault}}
  localparam int NV = 19;
  localparam logic [14:0] VEC [NV] = '{
    {4'd0,  2'b00, 2'b01, 1'b0, 2'b00, 1'b1, 3'b010}, // R2
    {4'd5,  2'b00, 2'b01, 1'b0, 2'b01, 1'b0, 3'b010}, // R2
    {4'd15, 2'b10, 2'b01, 1'b0, 2'b00, 1'b1, 3'b010}, // R3
    {4'd3,  2'b01, 2'b01, 1'b0, 2'b01, 1'b0, 3'b100}, // R4
    {4'd3,  2'b01, 2'b00, 1'b0, 2'b00, 1'b0, 3'b001}, // R4
    {4'd3,  2'b01, 2'b00, 1'b0, 2'b01, 1'b1, 3'b100}, // R4
    {4'd7,  2'b01, 2'b10, 1'b0, 2'b01, 1'b1, 3'b001}, // R4
    {4'd7,  2'b01, 2'b10, 1'b0, 2'b00, 1'b0, 3'b100}, // R4
    {4'd9,  2'b01, 2'b11, 1'b0, 2'b00, 1'b0, 3'b001}, // R4
    {4'd9,  2'b01, 2'b11, 1'b0, 2'b01, 1'b1, 3'b001}, // R4
    {4'd9,  2'b01, 2'b11, 1'b0, 2'b00, 1'b1, 3'b100}, // R4
    {4'd2,  2'b01, 2'b01, 1'b1, 2'b10, 1'b0, 3'b001}, // R5
    {4'd2,  2'b01, 2'b01, 1'b1, 2'b00, 1'b0, 3'b100}, // R5
    {4'd2,  2'b01, 2'b01, 1'b0, 2'b10, 1'b0, 3'b100}, // R5
    {4'd12, 2'b11, 2'b11, 1'b1, 2'b10, 1'b0, 3'b100}, // R6
    {4'd12, 2'b11, 2'b00, 1'b0, 2'b01, 1'b0, 3'b100}, // R6
    {4'd4,  2'b01, 2'b10, 1'b0, 2'b11, 1'b0, 3'b100}, // R10
    {4'd4,  2'b01, 2'b01, 1'b1, 2'b11, 1'b0, 3'b100}, // R10
    {4'd1,  2'b10, 2'b01, 1'b0, 2'b10, 1'b1, 3'b010}  // R3
  };

  // Place the mode in the chosen field, every other field gets its complement (R1).
  function automatic logic [31:0] make_ctrl(input logic [3:0] d, input logic [1:0] m);
    logic [31:0] w;
    for (int k = 0; k < 16; k++) w[2*k +: 2] = (k == int'(d)) ? m : ~m;
    return w;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {valid,pass,df,pf}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [14:0] v);
    dom_idx   = v[14:11];
    dom_ctrl  = make_ctrl(v[14:11], v[10:9]);
    perm_code = v[8:7];
    no_exec   = v[6];
    acc_kind  = v[5:4];
    acc_priv  = v[3];
    in_valid  = 1'b1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got run still active expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 in reset", {out_valid, out_pass, out_dom_fault, out_perm_fault}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", {out_valid, out_pass, out_dom_fault, out_perm_fault}, 4'b0000);

    // Table walk: one-cycle requests, result at the following falling edge.
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R1/R7 vector %0d", i),
            {out_valid, out_pass, out_dom_fault, out_perm_fault}, {1'b1, VEC[i][2:0]});
      @(negedge clk);
    end

    // R8: no request, inputs scrambled; result held and valid low.
    dom_ctrl = 32'h0000_0000; perm_code = 2'b00; acc_priv = 1'b0;
    @(negedge clk);
    check("R8 hold", {out_valid, out_pass, out_dom_fault, out_perm_fault},
          {1'b0, VEC[NV-1][2:0]});

    // R1: highest field only trusted, all others blocked.
    dom_idx = 4'd15; dom_ctrl = 32'hC000_0000; perm_code = 2'b11;
    acc_kind = 2'b01; acc_priv = 1'b0; no_exec = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 top field", {out_valid, out_pass, out_dom_fault, out_perm_fault}, 4'b1100);

    // R1: lowest field blocked while all others trusted.
    dom_idx = 4'd0; dom_ctrl = 32'hFFFF_FFFC; in_valid = 1'b1;
    @(negedge clk);
    check("R1 bottom field", {out_valid, out_pass, out_dom_fault, out_perm_fault}, 4'b1010);

    // R8: back-to-back requests, each result on its own cycle.
    dom_idx = 4'd6; dom_ctrl = 32'h0000_1000; perm_code = 2'b00; acc_priv = 1'b0;
    acc_kind = 2'b00;
    @(negedge clk);
    check("R8 back-to-back", {out_valid, out_pass, out_dom_fault, out_perm_fault}, 4'b1001);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 valid drops", {out_valid, out_pass, out_dom_fault, out_perm_fault}, 4'b0001);

    // R9: reset mid-run clears outputs.
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset again", {out_valid, out_pass, out_dom_fault, out_perm_fault}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule